// File: doc/BRIEF.md
# Column-Multiplexed ROM Fault Locator and Repair Sequencer

This block runs the self-repair pass for a ROM whose physical rows each hold several interleaved words, one per column position. For each column position in turn it reads every row of that position and folds the words into two residues. The first is a toggle residue, an XOR of all words. The second is a signature residue, a linear feedback shift register that takes the words in as they arrive. Both residues start from reference values that are fixed as parameters. If the toggle residue is nonzero after the sweep, the signature register is run backwards with the inverse feedback while the row counter counts down. The row at which the register equals the toggle residue is the faulty row. The toggle residue is also the error pattern, so XORing it with the stored word gives the corrected word.

Each corrected word goes to an external repair store as an (address, data) request. Once every column position has been handled, the block asks an external compactor to re-test the array and folds that result into a sticky repair-failure status. The ROM is read through a combinational port: the data input must reflect `rom_addr` in the same cycle.

Top module: `dg_rom_diag_seq`

## Requirements
- R1: After reset, `busy`, `done`, `rep_valid`, `retest_start` and `repair_fail` are all low.
- R2: A ROM word address is `{row, column}`: the low `COL_BITS` bits select the column position and the upper bits select the row. Repair requests use the same layout and are issued in ascending column order.
- R3: When the array matches the reference residues, no repair request is issued and `repair_fail` stays low.
- R4: A single corrupted word within a column position produces exactly one repair request. Its address is that word's address and its data is the fault-free word.
- R5: Faults in row 0 and in the last row are located correctly, including when several column positions each carry one fault.
- R6: `rep_valid` stays high, with `rep_addr` and `rep_data` unchanged, until the cycle in which `rep_ready` is high. That cycle is the transfer. No back-pressure limit applies.
- R7: A run issues at most `SPARES` repair requests. A fault located after the spares are used up sets `repair_fail`.
- R8: After the last column position, `retest_start` pulses for one cycle exactly once per run. `retest_done` together with `retest_fail` high sets `repair_fail`.
- R9: `done` is a one-cycle pulse, one cycle after `retest_done` is seen. `busy` is high from the cycle after `start` until `done` rises, and low while `done` is high.
- R10: `start` clears `repair_fail` when the block is idle and is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a repair run (idle only) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| repair_fail | output | 1 | Sticky repair-failure status |
| rom_addr | output | ADDR_W | ROM read address `{row, column}` |
| rom_data | input | DATA_W | ROM word at `rom_addr`, same cycle |
| rep_valid | output | 1 | Repair request valid |
| rep_ready | input | 1 | Repair store accepts request |
| rep_addr | output | ADDR_W | Faulty word address |
| rep_data | output | DATA_W | Corrected word |
| retest_start | output | 1 | Pulse to start the external re-test |
| retest_done | input | 1 | Re-test finished (one cycle) |
| retest_fail | input | 1 | Re-test result, valid with `retest_done` |

## Verification
The bound checker watches the per-cycle rules on every cycle:
- request stability under back-pressure;
- the spare cap;
- the single-cycle `done` and `retest_start` pulses;
- quiet outputs while idle;
- status clearing at start.

Whether a located row and its corrected word are right can only be shown by the bench's scenarios. So can column ordering, boundary rows, the effect of a failed re-test, and the ignored mid-run start. The bench does this against fault-free words that it computes on its own.

// File: rtl/dg_pkg.sv
package dg_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_PRESET, ST_SWEEP, ST_CHECK, ST_SEARCH,
    ST_FIX, ST_WRITE, ST_NEXT, ST_RETEST, ST_WAIT
  } dg_state_e;

  typedef enum logic [1:0] {
    RES_HOLD, RES_PRESET, RES_LOAD, RES_BACK
  } dg_res_op_e;
endpackage

// File: rtl/dg_addr_gen.sv
module dg_addr_gen #(
  parameter int ROW_W    = 4,
  parameter int COL_BITS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                row_clr,
  input  logic                row_inc,
  input  logic                row_dec,
  input  logic                col_clr,
  input  logic                col_inc,
  output logic [ROW_W-1:0]    row,
  output logic [COL_BITS-1:0] col,
  output logic                row_first,
  output logic                row_last,
  output logic                col_last
);
  localparam logic [ROW_W-1:0]    ROW_MAX = '1;
  localparam logic [COL_BITS-1:0] COL_MAX = '1;

  // row counter: up during the sweep, down during the search
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       row <= '0;
    else if (row_clr) row <= '0;
    else if (row_inc) row <= row + 1'b1;
    else if (row_dec) row <= row - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       col <= '0;
    else if (col_clr) col <= '0;
    else if (col_inc) col <= col + 1'b1;
  end

  assign row_first = (row == '0);
  assign row_last  = (row == ROW_MAX);
  assign col_last  = (col == COL_MAX);
endmodule

// File: rtl/dg_residue.sv
module dg_residue
  import dg_pkg::*;
#(
  parameter int                DATA_W = 8,
  parameter logic [DATA_W-1:0] POLY   = 8'hB8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dg_res_op_e        op,
  input  logic [DATA_W-1:0] pre_tog,
  input  logic [DATA_W-1:0] pre_sig,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] tog,
  output logic              tog_zero,
  output logic              hit
);
  logic [DATA_W-1:0] sig;

  // forward Galois step, shifting toward bit 0
  function automatic logic [DATA_W-1:0] step_fwd(input logic [DATA_W-1:0] s);
    return (s >> 1) ^ (s[0] ? POLY : '0);
  endfunction

  // inverse step (reciprocal polynomial): undoes one step_fwd
  function automatic logic [DATA_W-1:0] step_back(input logic [DATA_W-1:0] s);
    logic              b;
    logic [DATA_W-1:0] t;
    b = s[DATA_W-1];
    t = s ^ (b ? POLY : '0);
    return {t[DATA_W-2:0], b};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog <= '0;
      sig <= '0;
    end else begin
      case (op)
        RES_PRESET: begin
          tog <= pre_tog;
          sig <= pre_sig;
        end
        RES_LOAD: begin
          tog <= tog ^ din;
          sig <= step_fwd(sig) ^ din;
        end
        RES_BACK: sig <= step_back(sig);
        default: ;
      endcase
    end
  end

  assign tog_zero = (tog == '0);
  assign hit      = (sig == tog);
endmodule

// File: rtl/dg_rom_diag_seq.sv
module dg_rom_diag_seq
  import dg_pkg::*;
#(
  parameter int                             ADDR_W   = 6,
  parameter int                             COL_BITS = 2,
  parameter int                             DATA_W   = 8,
  parameter logic [DATA_W-1:0]              POLY     = 8'hB8,
  parameter int                             SPARES   = 2,
  parameter logic [(2**COL_BITS)*DATA_W-1:0] TOG_REF = '0,
  parameter logic [(2**COL_BITS)*DATA_W-1:0] SIG_REF = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              repair_fail,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [DATA_W-1:0] rom_data,
  output logic              rep_valid,
  input  logic              rep_ready,
  output logic [ADDR_W-1:0] rep_addr,
  output logic [DATA_W-1:0] rep_data,
  output logic              retest_start,
  input  logic              retest_done,
  input  logic              retest_fail
);
  localparam int ROW_W = ADDR_W - COL_BITS;
  localparam int SP_W  = $clog2(SPARES + 1);
  localparam logic [SP_W-1:0] SP_MAX = SP_W'(SPARES);

  dg_state_e         st, nxt;
  dg_res_op_e        op;
  logic              row_clr, row_inc, row_dec, col_clr, col_inc;
  logic              row_first, row_last, col_last;
  logic [ROW_W-1:0]  row;
  logic [COL_BITS-1:0] col;
  logic [DATA_W-1:0] tog;
  logic              tog_zero, hit;
  logic              fail_set, use_inc;
  logic [SP_W-1:0]   used;
  logic [DATA_W-1:0] fix_word;
  logic              done_q, fail_q;

  dg_addr_gen #(.ROW_W(ROW_W), .COL_BITS(COL_BITS)) u_addr (
    .clk(clk), .rst_n(rst_n),
    .row_clr(row_clr), .row_inc(row_inc), .row_dec(row_dec),
    .col_clr(col_clr), .col_inc(col_inc),
    .row(row), .col(col),
    .row_first(row_first), .row_last(row_last), .col_last(col_last)
  );

  dg_residue #(.DATA_W(DATA_W), .POLY(POLY)) u_res (
    .clk(clk), .rst_n(rst_n), .op(op),
    .pre_tog(TOG_REF[col*DATA_W +: DATA_W]),
    .pre_sig(SIG_REF[col*DATA_W +: DATA_W]),
    .din(rom_data),
    .tog(tog), .tog_zero(tog_zero), .hit(hit)
  );

  wire spares_full = (used == SP_MAX);

  always_comb begin
    nxt      = st;
    op       = RES_HOLD;
    row_clr  = 1'b0;
    row_inc  = 1'b0;
    row_dec  = 1'b0;
    col_clr  = 1'b0;
    col_inc  = 1'b0;
    fail_set = 1'b0;
    use_inc  = 1'b0;
    case (st)
      ST_IDLE: if (start) begin
        col_clr = 1'b1;
        nxt     = ST_PRESET;
      end
      ST_PRESET: begin
        op      = RES_PRESET;
        row_clr = 1'b1;
        nxt     = ST_SWEEP;
      end
      ST_SWEEP: begin
        op = RES_LOAD;
        if (row_last) nxt = ST_CHECK;
        else          row_inc = 1'b1;
      end
      ST_CHECK: nxt = tog_zero ? ST_NEXT : ST_SEARCH;
      ST_SEARCH: begin
        if (hit) begin
          if (spares_full) begin
            fail_set = 1'b1;
            nxt      = ST_NEXT;
          end else begin
            nxt = ST_FIX;
          end
        end else if (row_first) begin
          // wrapped through every row without a match
          fail_set = 1'b1;
          nxt      = ST_NEXT;
        end else begin
          op      = RES_BACK;
          row_dec = 1'b1;
        end
      end
      ST_FIX: nxt = ST_WRITE;
      ST_WRITE: if (rep_ready) begin
        use_inc = 1'b1;
        nxt     = ST_NEXT;
      end
      ST_NEXT: begin
        if (col_last) nxt = ST_RETEST;
        else begin
          col_inc = 1'b1;
          nxt     = ST_PRESET;
        end
      end
      ST_RETEST: nxt = ST_WAIT;
      ST_WAIT: if (retest_done) begin
        fail_set = retest_fail;
        nxt      = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      used     <= '0;
      fix_word <= '0;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
    end else begin
      st     <= nxt;
      done_q <= (st == ST_WAIT) && retest_done;
      if (st == ST_IDLE && start) begin
        used   <= '0;
        fail_q <= 1'b0;
      end else begin
        if (use_inc)  used   <= used + 1'b1;
        if (fail_set) fail_q <= 1'b1;
      end
      if (st == ST_FIX) fix_word <= rom_data ^ tog;
    end
  end

  assign rom_addr     = {row, col};
  assign rep_addr     = {row, col};
  assign rep_data     = fix_word;
  assign rep_valid    = (st == ST_WRITE);
  assign retest_start = (st == ST_RETEST);
  assign busy         = (st != ST_IDLE);
  assign done         = done_q;
  assign repair_fail  = fail_q;
endmodule

// File: rtl/dg_rom_diag_chk.sv
module dg_rom_diag_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int SPARES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              repair_fail,
  input logic              rep_valid,
  input logic              rep_ready,
  input logic [ADDR_W-1:0] rep_addr,
  input logic [DATA_W-1:0] rep_data,
  input logic              retest_start
);
  int unsigned xfers;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                xfers <= 0;
    else if (start && !busy)   xfers <= 0;
    else if (rep_valid && rep_ready) xfers <= xfers + 1;
  end

  a_r6_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid && !rep_ready |=> rep_valid && $stable(rep_addr) && $stable(rep_data));

  a_r7_spare_cap: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid |-> xfers < SPARES);

  a_r8_retest_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    retest_start |=> !retest_start);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rep_valid && !retest_start);

  a_r10_fail_clear: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> !repair_fail && busy);
endmodule

bind dg_rom_diag_seq dg_rom_diag_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SPARES(SPARES)
) u_chk (.*);

// File: tb/tb_dg_rom_diag_seq.sv
module tb_dg_rom_diag_seq;
  localparam int ADDR_W = 6;
  localparam int COLB   = 2;
  localparam int DW     = 8;
  localparam int NCOL   = 4;
  localparam int NROW   = 16;
  localparam logic [DW-1:0] POLY = 8'hB8;

  function automatic logic [DW-1:0] good_word(input int a);
    return DW'(a * 29 + 7) ^ DW'(a >> 1);
  endfunction

  function automatic logic [NCOL*DW-1:0] calc_tog();
    logic [NCOL*DW-1:0] v = '0;
    for (int c = 0; c < NCOL; c++)
      for (int r = 0; r < NROW; r++)
        v[c*DW +: DW] = v[c*DW +: DW] ^ good_word(r * NCOL + c);
    return v;
  endfunction

  // seed so that a fault-free sweep ends with a zero signature
  function automatic logic [NCOL*DW-1:0] calc_sig();
    logic [NCOL*DW-1:0] v = '0;
    for (int c = 0; c < NCOL; c++) begin
      logic [DW-1:0] s = '0;
      for (int r = NROW - 1; r >= 0; r--) begin
        logic [DW-1:0] x;
        logic b;
        x = s ^ good_word(r * NCOL + c);
        b = x[DW-1];
        x = x ^ (b ? POLY : '0);
        s = {x[DW-2:0], b};
      end
      v[c*DW +: DW] = s;
    end
    return v;
  endfunction

  localparam logic [NCOL*DW-1:0] TREF = calc_tog();
  localparam logic [NCOL*DW-1:0] SREF = calc_sig();

  logic clk = 0, rst_n = 0, start = 0;
  logic busy, done, repair_fail, rep_valid, retest_start;
  logic rep_ready = 1, retest_done = 0, retest_fail = 0;
  logic [ADDR_W-1:0] rom_addr, rep_addr;
  logic [DW-1:0] rom_data, rep_data;
  logic [DW-1:0] flt [64];

  always #4 clk = ~clk;

  assign rom_data = good_word(int'(rom_addr)) ^ flt[rom_addr];

  dg_rom_diag_seq #(
    .ADDR_W(ADDR_W), .COL_BITS(COLB), .DATA_W(DW), .POLY(POLY),
    .SPARES(2), .TOG_REF(TREF), .SIG_REF(SREF)
  ) dut (.*);

  int checks = 0, errors = 0, cyc = 0;
  int wr_n = 0, rt_n = 0, rt_wait = 0, tick = 0;
  int wr_addr [8];
  int wr_data [8];
  bit stall_mode = 0, rt_fail_cfg = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      errors++;
      $display("FAIL R9 watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // repair store and re-test responder, driven away from the active edge
  always @(negedge clk) begin
    tick++;
    rep_ready = stall_mode ? (tick % 4 == 0) : 1'b1;
    if (rep_valid && rep_ready && wr_n < 8) begin
      wr_addr[wr_n] = int'(rep_addr);
      wr_data[wr_n] = int'(rep_data);
      wr_n++;
    end
    retest_done = 0;
    if (rt_wait > 0) begin
      rt_wait--;
      if (rt_wait == 0) begin
        retest_done = 1;
        retest_fail = rt_fail_cfg;
      end
    end
    if (retest_start) begin
      rt_n++;
      rt_wait = 3;
    end
  end

  task automatic clear_faults();
    for (int i = 0; i < 64; i++) flt[i] = '0;
    wr_n = 0;
    rt_n = 0;
  endtask

  task automatic run(input bit poke_mid);
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    check(repair_fail == 0, "R10 status cleared at start", repair_fail, 0);
    check(busy == 1, "R9 busy after start", busy, 1);
    if (poke_mid) begin
      repeat (20) @(negedge clk);
      start = 1;
      @(negedge clk) start = 0;
    end
    while (!done) @(negedge clk);
    check(busy == 0, "R9 busy low with done", busy, 0);
    @(negedge clk);
    check(done == 0, "R9 done one cycle", done, 0);
  endtask

  task automatic t_reset();
    check(!busy && !done && !rep_valid && !retest_start && !repair_fail,
          "R1 reset outputs", {busy, done, rep_valid, retest_start, repair_fail}, 0);
  endtask

  task automatic t_clean();
    clear_faults();
    run(0);
    check(wr_n == 0, "R3 no repair writes", wr_n, 0);
    check(repair_fail == 0, "R3 status clear", repair_fail, 0);
    check(rt_n == 1, "R8 one retest pulse", rt_n, 1);
  endtask

  task automatic t_single();
    clear_faults();
    flt[21] = 8'h24;             // row 5, column 1
    run(1);                      // R10: mid-run start ignored
    check(wr_n == 1, "R4 one write", wr_n, 1);
    check(wr_addr[0] == 21, "R4 write address", wr_addr[0], 21);
    check(wr_data[0] == int'(good_word(21)), "R4 corrected data",
          wr_data[0], int'(good_word(21)));
    check(rt_n == 1, "R10 start ignored while busy", rt_n, 1);
    check(repair_fail == 0, "R4 status clear", repair_fail, 0);
  endtask

  task automatic t_boundary();
    clear_faults();
    flt[0]  = 8'h81;             // row 0, column 0
    flt[63] = 8'h01;             // last row, column 3
    stall_mode = 1;              // R6 back-pressure on the store
    run(0);
    stall_mode = 0;
    check(wr_n == 2, "R5 two writes", wr_n, 2);
    check(wr_addr[0] == 0, "R2 R5 first write row0 col0", wr_addr[0], 0);
    check(wr_addr[1] == 63, "R2 R5 second write last row col3", wr_addr[1], 63);
    check(wr_data[0] == int'(good_word(0)), "R5 R6 data row0", wr_data[0], int'(good_word(0)));
    check(wr_data[1] == int'(good_word(63)), "R5 R6 data last row", wr_data[1], int'(good_word(63)));
    check(repair_fail == 0, "R5 status clear", repair_fail, 0);
  endtask

  task automatic t_spares();
    clear_faults();
    flt[12] = 8'h10;             // row 3 col 0
    flt[29] = 8'h42;             // row 7 col 1
    flt[38] = 8'h07;             // row 9 col 2
    run(0);
    check(wr_n == 2, "R7 capped at spares", wr_n, 2);
    check(wr_addr[0] == 12 && wr_addr[1] == 29, "R2 R7 column order",
          wr_addr[1], 29);
    check(repair_fail == 1, "R7 status set", repair_fail, 1);
  endtask

  task automatic t_retest_fail();
    clear_faults();
    rt_fail_cfg = 1;
    run(0);
    rt_fail_cfg = 0;
    check(wr_n == 0, "R8 no writes", wr_n, 0);
    check(repair_fail == 1, "R8 retest failure sets status", repair_fail, 1);
    run(0);
    check(repair_fail == 0, "R10 next run clears status", repair_fail, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) flt[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_single();
    t_boundary();
    t_spares();
    t_retest_fail();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule